// File: doc/BRIEF.md
# Two-Phase Page Transfer Sequencer

This block moves a single 512-byte page between a local page buffer and system memory. It splits the move into two chained hardware phases. In the card phase, words move between the local buffer and the storage card over a simple request/acknowledge port. In the memory phase, words move between the local buffer and system memory over a separate request/acknowledge master port. The transfer direction sets the order. A read from the card runs the card phase and then the memory phase. A write to the card runs the memory phase and then the card phase.

Software uses a small register interface to program the memory base address and the interrupt enables, and to start a transfer in a chosen direction. A start only takes effect when both capability strap bits are set. A stage count shows progress. Each completed phase sets its own status bit. An acknowledged beat that carries an error aborts the transfer at any stage. When the transfer ends, by completion or by abort, the block clears its own settings and interrupt enables and gives a one-cycle done or fail pulse.

Top module: `pgdma_seq`

## Requirements
- R1: After reset no port request is raised, and the settings, status, enable, stage and base registers all read zero.
- R2: Writing 1 to bit 0 of the settings register (address 0) starts a transfer only when the block is idle and both capability bits read at address 4 are 1. Otherwise the write leaves the block idle and the settings register reads 0.
- R3: When settings bit 1 is 1 at start (read), the card phase runs first with card_we low, and the memory phase runs second with mem_we high. Each word taken from the card reaches memory unchanged.
- R4: When settings bit 1 is 0 at start (write), the memory phase runs first with mem_we low, and the card phase runs second with card_we high. Each word taken from memory reaches the card unchanged.
- R5: The stage register (address 5) reads 1 during the first phase and 2 during the second. While busy, settings reads bit 0 = 1 and bit 1 = the direction.
- R6: Each phase is 128 beats of 32 bits. Beat n carries page bytes 4n to 4n+3, with byte 4n+k in bits 8k+7:8k. mem_addr equals the word-aligned base (address 1, bits 1:0 forced to 0) plus 4n. A beat completes only on an acknowledge of the requesting port.
- R7: Status register (address 3) bit 0 is set when the card phase completes, bit 1 when the memory phase completes, and bit 2 on an error abort. Each bit is set whatever its enable (address 2, same bit order). irq is high while any status bit and its enable are both 1.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it. A hardware set in the same cycle wins.
- R9: An acknowledge with its error line high on the requesting port, in either phase, aborts the transfer. It sets status bit 2, pulses xfer_fail for one cycle, drops the requests, and returns settings, enables and stage to 0.
- R10: The acknowledge of the last beat of the second phase ends the transfer. In the next cycle xfer_done pulses for one cycle, and settings, enables and stage read 0.
- R11: An acknowledge or error on a port that is not requesting, including while idle, changes no status and produces no done or fail pulse.
- R12: While a transfer is active, writes to the settings and base registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| cap_bits | input | 2 | Capability straps; both 1 allow transfers |
| irq | output | 1 | OR of enabled status bits |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_fail | output | 1 | One-cycle abort pulse |
| card_req | output | 1 | Card-side beat request |
| card_we | output | 1 | 1 when the beat goes to the card |
| card_wdata | output | 32 | Word to the card |
| card_rdata | input | 32 | Word from the card |
| card_ack | input | 1 | Card beat acknowledge |
| card_err | input | 1 | Card beat error, qualified by card_ack |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 when the beat writes memory |
| mem_addr | output | 32 | Memory byte address of the beat |
| mem_wdata | output | 32 | Word to memory |
| mem_rdata | input | 32 | Word from memory |
| mem_ack | input | 1 | Memory beat acknowledge |
| mem_err | input | 1 | Memory beat error, qualified by mem_ack |

## Verification
The assertions assume that an acknowledge and its error line are only meaningful in a cycle where the matching request is high. They also assume that the environment holds its inputs stable across each rising edge. The stimulus drives every input half a cycle away from the edge. It acknowledges only the port that is requesting, either every cycle or with pseudo-random stalls. The one exception is a deliberate burst of stray acknowledges and errors while the block is idle, which checks that such inputs are ignored.

// File: rtl/pgdma_pkg.sv
package pgdma_pkg;
  localparam logic [2:0] A_SETUP = 3'd0;
  localparam logic [2:0] A_BASE  = 3'd1;
  localparam logic [2:0] A_IEN   = 3'd2;
  localparam logic [2:0] A_ISTAT = 3'd3;
  localparam logic [2:0] A_CAPS  = 3'd4;
  localparam logic [2:0] A_STAGE = 3'd5;

  localparam int EV_CARD = 0;
  localparam int EV_MEM  = 1;
  localparam int EV_ERR  = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } stage_e;
endpackage

// File: rtl/pgdma_buf.sv
module pgdma_buf #(
  parameter int DW = 32,
  parameter int BEATS = 128,
  localparam int BW = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [BW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] words [BEATS];

  always_ff @(posedge clk) begin
    if (we) words[idx] <= wdata;
  end

  assign rdata = words[idx];
endmodule

// File: rtl/pgdma_ctrl.sv
module pgdma_ctrl import pgdma_pkg::*; #(
  parameter int BEATS = 128,
  localparam int BW = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_dir,
  input  logic          card_ack,
  input  logic          card_err,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          active,
  output logic          dir_rd,
  output stage_e        stage,
  output logic [BW-1:0] beat,
  output logic          card_req,
  output logic          card_we,
  output logic          mem_req,
  output logic          mem_we,
  output logic          buf_we,
  output logic [2:0]    ev,
  output logic          ending,
  output logic          done,
  output logic          fail
);
  stage_e        stage_q, stage_d;
  logic          dir_q, dir_d;
  logic [BW-1:0] beat_q, beat_d;
  logic          done_q, done_d, fail_q, fail_d;
  logic          on_card, hit, hit_err, good, bad, last;

  assign active   = (stage_q != ST_IDLE);
  assign on_card  = ((stage_q == ST_FIRST) == dir_q);
  assign card_req = active && on_card;
  assign mem_req  = active && !on_card;
  assign card_we  = card_req && !dir_q;
  assign mem_we   = mem_req && dir_q;
  assign hit      = (card_req && card_ack) || (mem_req && mem_ack);
  assign hit_err  = card_req ? card_err : mem_err;
  assign good     = hit && !hit_err;
  assign bad      = hit && hit_err;
  assign last     = (beat_q == BW'(BEATS - 1));
  assign buf_we   = good && ((card_req && dir_q) || (mem_req && !dir_q));

  always_comb begin
    stage_d = stage_q;
    dir_d   = dir_q;
    beat_d  = beat_q;
    done_d  = 1'b0;
    fail_d  = 1'b0;
    ev      = '0;
    ending  = 1'b0;
    if (stage_q == ST_IDLE) begin
      if (start) begin
        stage_d = ST_FIRST;
        dir_d   = start_dir;
        beat_d  = '0;
      end
    end else if (bad) begin
      stage_d    = ST_IDLE;
      dir_d      = 1'b0;
      beat_d     = '0;
      fail_d     = 1'b1;
      ending     = 1'b1;
      ev[EV_ERR] = 1'b1;
    end else if (good) begin
      if (last) begin
        beat_d = '0;
        ev[on_card ? EV_CARD : EV_MEM] = 1'b1;
        if (stage_q == ST_SECOND) begin
          stage_d = ST_IDLE;
          dir_d   = 1'b0;
          done_d  = 1'b1;
          ending  = 1'b1;
        end else begin
          stage_d = ST_SECOND;
        end
      end else begin
        beat_d = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      dir_q   <= 1'b0;
      beat_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      dir_q   <= dir_d;
      beat_q  <= beat_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign dir_rd = dir_q;
  assign stage  = stage_q;
  assign beat   = beat_q;
  assign done   = done_q;
  assign fail   = fail_q;

  // R3 / R4: only one side is served at a time
  p_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_req && mem_req));
  // R10: completion only follows the second phase
  p_done_after_second_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(stage_q) == ST_SECOND) && !active);
  // R9: abort only follows an error input
  p_fail_has_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> $past(card_err || mem_err));
  // R11: an idle cycle never yields a done or fail pulse
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_IDLE) |=> !done_q && !fail_q);
  // R6: without an acknowledge the beat position holds
  p_beat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !hit) |=> $stable(beat_q) && $stable(stage_q));
endmodule

// File: rtl/pgdma_regs.sv
module pgdma_regs import pgdma_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [1:0]        cap,
  input  logic              active,
  input  logic              dir_rd,
  input  stage_e            stage,
  input  logic [2:0]        ev,
  input  logic              ending,
  output logic              start,
  output logic              start_dir,
  output logic [ADDR_W-1:0] base,
  output logic              irq
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [2:0]        ien_q, ien_d, sta_q, sta_d, clr;
  logic              base_en;

  assign start     = reg_we && (reg_addr == A_SETUP) && reg_wdata[0] && !active && (cap == 2'b11);
  assign start_dir = reg_wdata[1];
  assign base_en   = reg_we && (reg_addr == A_BASE) && !active;
  assign clr       = (reg_we && (reg_addr == A_ISTAT)) ? reg_wdata[2:0] : 3'b000;

  always_comb begin
    base_d = base_q;
    if (base_en) base_d = {reg_wdata[ADDR_W-1:2], 2'b00};
    ien_d = ien_q;
    if (ending) ien_d = 3'b000;
    else if (reg_we && (reg_addr == A_IEN)) ien_d = reg_wdata[2:0];
    sta_d = (sta_q & ~clr) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ien_q  <= '0;
      sta_q  <= '0;
    end else begin
      base_q <= base_d;
      ien_q  <= ien_d;
      sta_q  <= sta_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SETUP: reg_rdata[1:0]        = {dir_rd, active};
      A_BASE:  reg_rdata[ADDR_W-1:0] = base_q;
      A_IEN:   reg_rdata[2:0]        = ien_q;
      A_ISTAT: reg_rdata[2:0]        = sta_q;
      A_CAPS:  reg_rdata[1:0]        = cap;
      A_STAGE: reg_rdata[1:0]        = stage;
      default: reg_rdata             = '0;
    endcase
  end

  assign base = base_q;
  assign irq  = |(sta_q & ien_q);

  // R8: a software clear with no event leaves only the uncleared bits
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == A_ISTAT) && (ev == 3'b000)) |=> (sta_q == ($past(sta_q) & ~$past(reg_wdata[2:0]))));
  // R10 / R9: ending a transfer leaves every enable cleared
  p_en_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ending |=> (ien_q == 3'b000));
  // R12: base holds while busy
  p_base_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(base_q));
endmodule

// File: rtl/pgdma_seq.sv
module pgdma_seq import pgdma_pkg::*; #(
  parameter int PAGE_BYTES = 512,
  parameter int DW = 32,
  parameter int ADDR_W = 32,
  localparam int BEATS = PAGE_BYTES / (DW / 8),
  localparam int BW = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [1:0]        cap_bits,
  output logic              irq,
  output logic              xfer_done,
  output logic              xfer_fail,
  output logic              card_req,
  output logic              card_we,
  output logic [DW-1:0]     card_wdata,
  input  logic [DW-1:0]     card_rdata,
  input  logic              card_ack,
  input  logic              card_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);
  logic [1:0]        rsync_q;
  logic              core_rst_n;
  logic              start, start_dir, active, dir_rd, buf_we, ending;
  stage_e            stage;
  logic [BW-1:0]     beat;
  logic [2:0]        ev;
  logic [ADDR_W-1:0] base;
  logic [DW-1:0]     buf_wdata, buf_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  pgdma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(core_rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap(cap_bits),
    .active(active), .dir_rd(dir_rd), .stage(stage), .ev(ev), .ending(ending),
    .start(start), .start_dir(start_dir), .base(base), .irq(irq)
  );

  pgdma_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk(clk), .rst_n(core_rst_n), .start(start), .start_dir(start_dir),
    .card_ack(card_ack), .card_err(card_err), .mem_ack(mem_ack), .mem_err(mem_err),
    .active(active), .dir_rd(dir_rd), .stage(stage), .beat(beat),
    .card_req(card_req), .card_we(card_we), .mem_req(mem_req), .mem_we(mem_we),
    .buf_we(buf_we), .ev(ev), .ending(ending), .done(xfer_done), .fail(xfer_fail)
  );

  assign buf_wdata = dir_rd ? card_rdata : mem_rdata;

  pgdma_buf #(.DW(DW), .BEATS(BEATS)) u_buf (
    .clk(clk), .we(buf_we), .idx(beat), .wdata(buf_wdata), .rdata(buf_rdata)
  );

  assign card_wdata = buf_rdata;
  assign mem_wdata  = buf_rdata;
  assign mem_addr   = base + {{(ADDR_W-BW-2){1'b0}}, beat, 2'b00};

  // R6: consecutive accepted memory beats step the address by one word
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mem_req && $past(mem_req) && $past(mem_ack) && !$past(mem_err)) |-> (mem_addr == $past(mem_addr) + 4));
  // R2: a start without both capability bits leaves the block idle
  p_cap_gate_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_we && (reg_addr == A_SETUP) && reg_wdata[0] && (cap_bits != 2'b11) && !card_req && !mem_req)
      |=> !card_req && !mem_req);
endmodule

// File: tb/tb_pgdma_seq.sv
module tb_pgdma_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  cap_bits = 2'b00;
  logic        irq, xfer_done, xfer_fail;
  logic        card_req, card_we, card_ack = 1'b0, card_err = 1'b0;
  logic [31:0] card_wdata, card_rdata = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  pgdma_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_bits(cap_bits),
    .irq(irq), .xfer_done(xfer_done), .xfer_fail(xfer_fail),
    .card_req(card_req), .card_we(card_we), .card_wdata(card_wdata),
    .card_rdata(card_rdata), .card_ack(card_ack), .card_err(card_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err)
  );

  int checks = 0, fails = 0, cyc = 0, n_done = 0, n_fail = 0;
  int stall_mode = 0, err_after = -1;
  bit force_ack = 1'b0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  // behavioural model state
  bit          m_act, m_dir, m_done, m_fail;
  int          m_stage, m_beat;
  logic [31:0] m_base;
  logic [2:0]  m_en, m_sta;
  logic [31:0] m_buf [128];

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h exp %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    bit old_act, cur_card, fin, ab;
    logic [2:0] setb, clr;
    if (!rst_n) begin
      m_act = 0; m_dir = 0; m_stage = 0; m_beat = 0; m_base = '0;
      m_en = '0; m_sta = '0; m_done = 0; m_fail = 0;
    end else begin
      old_act = m_act; fin = 0; ab = 0; setb = '0; clr = '0;
      cur_card = ((m_stage == 1) == m_dir);
      if (old_act && (cur_card ? card_ack : mem_ack)) begin
        if (cur_card ? card_err : mem_err) begin
          ab = 1; setb = 3'b100;
        end else begin
          if (cur_card && m_dir) m_buf[m_beat] = card_rdata;
          if (!cur_card && !m_dir) m_buf[m_beat] = mem_rdata;
          if (m_beat == 127) begin
            setb = cur_card ? 3'b001 : 3'b010;
            m_beat = 0;
            if (m_stage == 2) fin = 1; else m_stage = 2;
          end else m_beat++;
        end
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: if (!old_act && reg_wdata[0] && cap_bits == 2'b11) begin
                  m_act = 1; m_dir = reg_wdata[1]; m_stage = 1; m_beat = 0;
                end
          3'd1: if (!old_act) m_base = reg_wdata & 32'hFFFF_FFFC;
          3'd2: m_en = reg_wdata[2:0];
          3'd3: clr = reg_wdata[2:0];
          default: ;
        endcase
      end
      if (fin || ab) begin
        m_act = 0; m_dir = 0; m_stage = 0; m_beat = 0; m_en = '0;
      end
      m_sta = (m_sta & ~clr) | setb;
      m_done = fin; m_fail = ab;
    end
  end

  // per-clock comparison, then acknowledge responder
  always @(negedge clk) begin : cmp_drive
    bit ecard, emem, go;
    if (rst_n) begin
      ecard = m_act && ((m_stage == 1) == m_dir);
      emem  = m_act && !((m_stage == 1) == m_dir);
      chk(card_req === ecard, "R3/R4 card_req", card_req, ecard);
      chk(mem_req === emem, "R3/R4 mem_req", mem_req, emem);
      if (ecard) chk(card_we === !m_dir, "R3/R4 card_we", card_we, !m_dir);
      if (emem)  chk(mem_we === m_dir, "R3/R4 mem_we", mem_we, m_dir);
      if (emem)  chk(mem_addr === m_base + 32'(4 * m_beat), "R6 mem_addr", mem_addr, m_base + 32'(4 * m_beat));
      if (emem && m_dir) chk(mem_wdata === m_buf[m_beat], "R3 mem_wdata", mem_wdata, m_buf[m_beat]);
      if (ecard && !m_dir) chk(card_wdata === m_buf[m_beat], "R4 card_wdata", card_wdata, m_buf[m_beat]);
      chk(irq === |(m_sta & m_en), "R7 irq", irq, |(m_sta & m_en));
      chk(xfer_done === m_done, "R10 xfer_done", xfer_done, m_done);
      chk(xfer_fail === m_fail, "R9 xfer_fail", xfer_fail, m_fail);
      if (xfer_done) n_done++;
      if (xfer_fail) n_fail++;
    end
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    go = (stall_mode == 0) || (lfsr[1:0] != 2'b00);
    card_ack = force_ack || (card_req && go);
    mem_ack  = force_ack || (mem_req && go);
    card_err = force_ack;
    mem_err  = force_ack;
    if (err_after >= 0 && ((card_req && card_ack) || (mem_req && mem_ack))) begin
      if (err_after == 0) begin
        card_err = card_req;
        mem_err  = mem_req;
      end
      err_after--;
    end
    card_rdata = lfsr ^ 32'h5A5A_0000;
    mem_rdata  = ~lfsr;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rchk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic wait_idle();
    while (m_act) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired got %0d exp below 100000", cyc);
      finish_run();
    end
  end

  initial begin
    int done0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rchk(3'd0, 32'h0, "R1 settings");
    rchk(3'd3, 32'h0, "R1 status");
    rchk(3'd2, 32'h0, "R1 enables");
    rchk(3'd5, 32'h0, "R1 stage");
    rchk(3'd1, 32'h0, "R1 base");

    // R2 capability gating
    cap_bits = 2'b01;
    wr(3'd0, 32'h3);
    rchk(3'd0, 32'h0, "R2 start refused cap=01");
    cap_bits = 2'b10;
    wr(3'd0, 32'h1);
    rchk(3'd5, 32'h0, "R2 start refused cap=10");
    cap_bits = 2'b11;
    rchk(3'd4, 32'h3, "R2 caps readback");

    // R3 read transfer, no stalls
    wr(3'd1, 32'h0000_1003);
    rchk(3'd1, 32'h0000_1000, "R6 base aligned");
    wr(3'd2, 32'h7);
    wr(3'd0, 32'h3);
    rchk(3'd5, 32'h1, "R5 stage first");
    rchk(3'd0, 32'h3, "R5 settings busy");
    wr(3'd1, 32'h0000_9000);
    wr(3'd0, 32'h1);
    rchk(3'd1, 32'h0000_1000, "R12 base locked");
    rchk(3'd0, 32'h3, "R12 settings locked");
    while (m_stage != 2) @(negedge clk);
    rchk(3'd5, 32'h2, "R5 stage second");
    rchk(3'd3, 32'h1, "R7 card phase bit");
    done0 = n_done;
    wait_idle();
    chk(n_done == done0 + 1, "R10 done pulse count", n_done, done0 + 1);
    rchk(3'd3, 32'h3, "R7 both phase bits");
    rchk(3'd2, 32'h0, "R10 enables cleared");
    rchk(3'd0, 32'h0, "R10 settings cleared");
    rchk(3'd5, 32'h0, "R10 stage idle");

    // R8 write-one-to-clear
    wr(3'd3, 32'h1);
    rchk(3'd3, 32'h2, "R8 clear bit0");
    wr(3'd3, 32'h4);
    rchk(3'd3, 32'h2, "R8 clear of zero bit");
    wr(3'd3, 32'h2);
    rchk(3'd3, 32'h0, "R8 clear bit1");

    // R4 write transfer with stalls
    stall_mode = 1;
    wr(3'd1, 32'h2000_0100);
    wr(3'd2, 32'h3);
    wr(3'd0, 32'h1);
    rchk(3'd0, 32'h1, "R4 settings write busy");
    wait_idle();
    rchk(3'd3, 32'h3, "R4 both phases done");

    // R9 error in second phase of a read
    wr(3'd3, 32'h7);
    err_after = 150;
    wr(3'd2, 32'h7);
    wr(3'd0, 32'h3);
    wait_idle();
    chk(n_fail == 1, "R9 fail pulse count", n_fail, 1);
    rchk(3'd3, 32'h5, "R9 status after late error");
    rchk(3'd2, 32'h0, "R9 enables cleared");
    rchk(3'd0, 32'h0, "R9 settings cleared");

    // R9 error in first phase of a write
    wr(3'd3, 32'h7);
    err_after = 10;
    wr(3'd0, 32'h1);
    wait_idle();
    rchk(3'd3, 32'h4, "R9 status after early error");
    rchk(3'd5, 32'h0, "R9 stage idle");

    // R11 stray acknowledges while idle
    wr(3'd3, 32'h7);
    done0 = n_done;
    force_ack = 1'b1;
    repeat (8) @(negedge clk);
    force_ack = 1'b0;
    rchk(3'd3, 32'h0, "R11 status untouched");
    rchk(3'd5, 32'h0, "R11 stage idle");
    chk(n_done == done0 && n_fail == 2, "R11 no pulses", n_done, done0);

    // second read after all of the above still completes
    stall_mode = 1;
    wr(3'd1, 32'h0000_0040);
    wr(3'd0, 32'h3);
    wait_idle();
    rchk(3'd3, 32'h3, "R3 read with stalls");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule